// File: doc/BRIEF.md
# Rename Map with Undo-Log Rollback

This block keeps the current logical-to-physical register assignment for an out-of-order core and an undo log of every assignment change. When a renamed instruction writes a destination, the block hands it the lowest-numbered free physical register and records three things in the log: the logical register, the new physical register and the physical register that logical register held before. Instructions that redirect a logical register to the constant-zero physical register also take a log slot, even though they consume no free register.

On a misprediction or exception the core names the log tag of the oldest instruction to discard. The block then walks the log from the youngest slot toward that tag, a bounded number of slots per cycle. Each undone slot writes its previous mapping back into the table and returns its new physical register to the free pool. Rename is held off during the walk. Retirement drains slots from the oldest end and returns each recorded previous register to the pool. Source operands are looked up combinationally against the current table.

Top module: `rmh_rename_unit`

## Requirements
- R1: After reset, logical register i maps to physical register i+1, physical register 0 is the constant-zero register and is never free, free_cnt equals NUM_PHYS-NUM_LOG-1, and ren_ready is high.
- R2: src_preg shows, in the same cycle, the physical register currently mapped to src_log, including a rename taken at the preceding clock edge.
- R3: A rename taken with ren_alloc=1 returns on ren_new_preg, in that cycle, the lowest-numbered free physical register. The map is updated for ren_log at the next edge, and free_cnt drops by one.
- R4: A rename taken with ren_alloc=0 maps ren_log to physical register 0 and uses one log slot, and free_cnt is unchanged. ren_tag is the slot's tag: a pointer into the log with one extra wrap bit, counting up by one per rename.
- R5: ren_ready is low while the log holds HIST_DEPTH slots, or when ren_alloc=1 and no physical register is free.
- R6: retire_cnt releases the oldest min(retire_cnt, held slots, STEPS) slots at the next edge. Each released slot returns its recorded previous register to the free pool unless that register is 0.
- R7: A flush_valid pulse with flush_tag raises rb_busy from the next edge. Each busy cycle undoes up to STEPS of the youngest slots, walking down to flush_tag. rb_busy falls at the edge that undoes the last of them. Afterwards the map equals its state before the undone renames, and every undone nonzero new register is free again.
- R8: ren_ready is low in the flush cycle and in every cycle with rb_busy high, and retire_cnt is ignored while rb_busy is high.
- R9: At most STEPS physical registers return to the free pool in any cycle, and a register already free is never returned.
- R10: A flush_valid pulse while rb_busy is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ren_valid | input | 1 | Rename request |
| ren_log | input | LW | Logical destination of the request |
| ren_alloc | input | 1 | 1: take a free physical register; 0: map to register 0 |
| ren_ready | output | 1 | Request is accepted this cycle |
| ren_new_preg | output | PW | Physical register given to the request |
| ren_tag | output | HW+1 | Log tag of the request |
| src_log | input | LW | Logical source to look up |
| src_preg | output | PW | Current mapping of src_log |
| retire_cnt | input | CW | Number of oldest slots to release |
| flush_valid | input | 1 | Start a rollback |
| flush_tag | input | HW+1 | Tag of the oldest slot to undo |
| rb_busy | output | 1 | Rollback walk in progress |
| free_cnt | output | PW+1 | Number of free physical registers |

## Verification
The bench builds the block with 8 logical registers, 16 physical registers, an 8-slot log and 2 steps per cycle. The small step count stretches a 4-slot rollback over two busy cycles. That exposes the intra-cycle ordering of restores to the same logical register, and gives a window for a second flush inside the walk. The 8-slot log lets the full condition, the pointer wrap bit and the retire cap all be reached in a few dozen cycles.

// File: rtl/rmh_pkg.sv
package rmh_pkg;
  localparam int ZERO_PREG = 0;

  function automatic int min3(input int a, input int b, input int c);
    int m;
    m = (a < b) ? a : b;
    return (m < c) ? m : c;
  endfunction

  function automatic int ptr_gap(input int young, input int old, input int bits);
    return (young - old) & ((1 << bits) - 1);
  endfunction
endpackage

// File: rtl/rmh_free_list.sv
module rmh_free_list #(
  parameter int NUM_PHYS = 16,
  parameter int NUM_LOG  = 8,
  localparam int PW = $clog2(NUM_PHYS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                alloc_en,
  input  logic [NUM_PHYS-1:0] free_mask,
  output logic                pick_vld,
  output logic [PW-1:0]       pick_idx,
  output logic [PW:0]         free_cnt
);
  logic [NUM_PHYS-1:0] free_q;
  logic [NUM_PHYS-1:0] alloc_oh;

  always_comb begin
    pick_vld = 1'b0;
    pick_idx = '0;
    for (int i = NUM_PHYS - 1; i >= 0; i--) begin
      if (free_q[i]) begin
        pick_vld = 1'b1;
        pick_idx = PW'(i);
      end
    end
  end

  always_comb begin
    free_cnt = '0;
    for (int i = 0; i < NUM_PHYS; i++) free_cnt = free_cnt + (PW+1)'(free_q[i]);
  end

  assign alloc_oh = alloc_en ? (NUM_PHYS'(1) << pick_idx) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_PHYS; i++) free_q[i] <= (i > NUM_LOG);
    end else begin
      free_q <= (free_q & ~alloc_oh) | free_mask;
    end
  end

  AST_ALLOC_FROM_FREE: assert property (@(posedge clk) disable iff (!rst_n) alloc_en |-> pick_vld); // R3
  AST_NO_DOUBLE_FREE: assert property (@(posedge clk) disable iff (!rst_n) (free_mask & free_q) == '0); // R9
  AST_ZERO_NEVER_FREE: assert property (@(posedge clk) disable iff (!rst_n) !free_q[0]); // R4
endmodule

// File: rtl/rmh_hist_log.sv
module rmh_hist_log #(
  parameter int LW    = 3,
  parameter int PW    = 4,
  parameter int DEPTH = 8,
  parameter int STEPS = 2,
  localparam int HW = $clog2(DEPTH),
  localparam int CW = $clog2(STEPS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [LW-1:0] push_log,
  input  logic [PW-1:0] push_new,
  input  logic [PW-1:0] push_old,
  input  logic [CW-1:0] pop_n,
  input  logic [CW-1:0] unwind_n,
  output logic [HW:0]   tail_ptr,
  output logic [HW:0]   count,
  output logic [LW-1:0] y_log [STEPS],
  output logic [PW-1:0] y_new [STEPS],
  output logic [PW-1:0] y_old [STEPS],
  output logic [PW-1:0] o_old [STEPS]
);
  logic [LW-1:0] e_log [DEPTH];
  logic [PW-1:0] e_new [DEPTH];
  logic [PW-1:0] e_old [DEPTH];
  logic [HW:0]   head_q, tail_q;

  assign tail_ptr = tail_q;
  assign count    = tail_q - head_q;

  always_comb begin
    for (int k = 0; k < STEPS; k++) begin
      logic [HW:0] yp, op;
      yp = tail_q - (HW+1)'(k + 1);
      op = head_q + (HW+1)'(k);
      y_log[k] = e_log[yp[HW-1:0]];
      y_new[k] = e_new[yp[HW-1:0]];
      y_old[k] = e_old[yp[HW-1:0]];
      o_old[k] = e_old[op[HW-1:0]];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
    end else begin
      tail_q <= tail_q + (HW+1)'(push) - (HW+1)'(unwind_n);
      head_q <= head_q + (HW+1)'(pop_n);
    end
  end

  always_ff @(posedge clk) begin
    if (push) begin
      e_log[tail_q[HW-1:0]] <= push_log;
      e_new[tail_q[HW-1:0]] <= push_new;
      e_old[tail_q[HW-1:0]] <= push_old;
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n) push |-> count != (HW+1)'(DEPTH)); // R5
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n) (HW+1)'(pop_n) + (HW+1)'(unwind_n) <= count); // R6
endmodule

// File: rtl/rmh_rename_unit.sv
module rmh_rename_unit #(
  parameter int NUM_LOG    = 8,
  parameter int NUM_PHYS   = 16,
  parameter int HIST_DEPTH = 8,
  parameter int STEPS      = 2,
  localparam int LW = $clog2(NUM_LOG),
  localparam int PW = $clog2(NUM_PHYS),
  localparam int HW = $clog2(HIST_DEPTH),
  localparam int CW = $clog2(STEPS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ren_valid,
  input  logic [LW-1:0] ren_log,
  input  logic          ren_alloc,
  output logic          ren_ready,
  output logic [PW-1:0] ren_new_preg,
  output logic [HW:0]   ren_tag,
  input  logic [LW-1:0] src_log,
  output logic [PW-1:0] src_preg,
  input  logic [CW-1:0] retire_cnt,
  input  logic          flush_valid,
  input  logic [HW:0]   flush_tag,
  output logic          rb_busy,
  output logic [PW:0]   free_cnt
);
  import rmh_pkg::*;

  logic [PW-1:0]       map_q [NUM_LOG];
  logic                rb_busy_q;
  logic [HW:0]         stop_q;
  logic                pick_vld, ren_fire, flush_start, hist_full;
  logic [PW-1:0]       pick_idx;
  logic [HW:0]         tail_ptr, count, remaining;
  logic [CW-1:0]       pop_n, unwind_n;
  logic [NUM_PHYS-1:0] free_mask;
  logic [LW-1:0]       y_log [STEPS];
  logic [PW-1:0]       y_new [STEPS];
  logic [PW-1:0]       y_old [STEPS];
  logic [PW-1:0]       o_old [STEPS];

  assign hist_full    = count == (HW+1)'(HIST_DEPTH);
  assign ren_ready    = !rb_busy_q && !flush_valid && !hist_full && (!ren_alloc || pick_vld);
  assign ren_fire     = ren_valid && ren_ready;
  assign ren_new_preg = ren_alloc ? pick_idx : PW'(ZERO_PREG);
  assign ren_tag      = tail_ptr;
  assign src_preg     = map_q[src_log];
  assign rb_busy      = rb_busy_q;
  assign flush_start  = flush_valid && !rb_busy_q;

  assign remaining = (HW+1)'(ptr_gap(int'(tail_ptr), int'(stop_q), HW + 1));
  assign unwind_n  = rb_busy_q ? CW'(min3(int'(remaining), STEPS, STEPS)) : '0;
  assign pop_n     = rb_busy_q ? '0 : CW'(min3(int'(retire_cnt), int'(count), STEPS));

  always_comb begin
    free_mask = '0;
    for (int k = 0; k < STEPS; k++) begin
      if (k < int'(pop_n) && o_old[k] != PW'(ZERO_PREG)) free_mask[o_old[k]] = 1'b1;
      if (k < int'(unwind_n) && y_new[k] != PW'(ZERO_PREG)) free_mask[y_new[k]] = 1'b1;
    end
  end

  rmh_free_list #(.NUM_PHYS(NUM_PHYS), .NUM_LOG(NUM_LOG)) u_free (
    .clk(clk), .rst_n(rst_n), .alloc_en(ren_fire && ren_alloc), .free_mask(free_mask),
    .pick_vld(pick_vld), .pick_idx(pick_idx), .free_cnt(free_cnt)
  );

  rmh_hist_log #(.LW(LW), .PW(PW), .DEPTH(HIST_DEPTH), .STEPS(STEPS)) u_hist (
    .clk(clk), .rst_n(rst_n), .push(ren_fire), .push_log(ren_log), .push_new(ren_new_preg),
    .push_old(map_q[ren_log]), .pop_n(pop_n), .unwind_n(unwind_n), .tail_ptr(tail_ptr),
    .count(count), .y_log(y_log), .y_new(y_new), .y_old(y_old), .o_old(o_old)
  );

  // Restores walk youngest first; a later (older) slot for the same register wins.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_LOG; i++) map_q[i] <= PW'(i + 1);
    end else begin
      if (ren_fire) map_q[ren_log] <= ren_new_preg;
      for (int k = 0; k < STEPS; k++) begin
        if (k < int'(unwind_n)) map_q[y_log[k]] <= y_old[k];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rb_busy_q <= 1'b0;
      stop_q    <= '0;
    end else if (flush_start) begin
      rb_busy_q <= 1'b1;
      stop_q    <= flush_tag;
    end else if (rb_busy_q && int'(remaining) <= STEPS) begin
      rb_busy_q <= 1'b0;
    end
  end

  AST_RB_BLOCKS_RENAME: assert property (@(posedge clk) disable iff (!rst_n) rb_busy_q |-> !ren_fire); // R8
  AST_RB_PROGRESS: assert property (@(posedge clk) disable iff (!rst_n)
    (rb_busy_q && remaining != '0) |=> count < $past(count)); // R7
  AST_FREE_LIMIT: assert property (@(posedge clk) disable iff (!rst_n) $countones(free_mask) <= STEPS); // R9
  AST_FLUSH_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (rb_busy_q && flush_valid) |=> $stable(stop_q)); // R10
endmodule

// File: tb/tb_rmh_rename_unit.sv
module tb_rmh_rename_unit;
  localparam int NL = 8, NP = 16, HD = 8, ST = 2;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic       ren_valid = 1'b0, ren_alloc = 1'b0, flush_valid = 1'b0, ren_ready, rb_busy;
  logic [2:0] ren_log = '0, src_log = '0;
  logic [3:0] ren_new_preg, src_preg, ren_tag, flush_tag = '0;
  logic [1:0] retire_cnt = '0;
  logic [4:0] free_cnt;
  int n_chk = 0, n_bad = 0, cyc = 0;

  // {log[7:5], alloc[4], expected preg[3:0]}
  localparam logic [7:0] REN_TAB [6] = '{
    {3'd3, 1'b1, 4'd9}, {3'd5, 1'b1, 4'd10}, {3'd3, 1'b1, 4'd11},
    {3'd0, 1'b0, 4'd0}, {3'd5, 1'b1, 4'd12}, {3'd1, 1'b1, 4'd13}};

  always #5 clk = ~clk;

  rmh_rename_unit #(.NUM_LOG(NL), .NUM_PHYS(NP), .HIST_DEPTH(HD), .STEPS(ST)) dut (
    .clk(clk), .rst_n(rst_n), .ren_valid(ren_valid), .ren_log(ren_log), .ren_alloc(ren_alloc),
    .ren_ready(ren_ready), .ren_new_preg(ren_new_preg), .ren_tag(ren_tag), .src_log(src_log),
    .src_preg(src_preg), .retire_cnt(retire_cnt), .flush_valid(flush_valid), .flush_tag(flush_tag),
    .rb_busy(rb_busy), .free_cnt(free_cnt));

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic map_is(input string req, input int lg, input int pr);
    src_log = 3'(lg);
    #1 chk(req, int'(src_preg), pr);
  endtask

  task automatic rename(input int lg, input bit al, input int exp_p, input int exp_tag);
    ren_valid = 1'b1; ren_log = 3'(lg); ren_alloc = al;
    #1;
    chk("R5 ready", int'(ren_ready), 1);
    chk(al ? "R3 new preg" : "R4 zero preg", int'(ren_new_preg), exp_p);
    chk("R4 tag", int'(ren_tag), exp_tag);
    tick();
    ren_valid = 1'b0;
    map_is("R2 lookup after rename", lg, exp_p);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  always @(posedge clk) cyc++;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    for (int i = 0; i < NL; i++) map_is("R1 reset map", i, i + 1);
    chk("R1 free count", int'(free_cnt), NP - NL - 1);
    chk("R1 ready", int'(ren_ready), 1);

    // Table walk: R3 R4 R2
    for (int i = 0; i < 6; i++) rename(int'(REN_TAB[i][7:5]), REN_TAB[i][4], int'(REN_TAB[i][3:0]), i);
    chk("R3 free after renames", int'(free_cnt), 2);

    // R7 rollback to tag 2, four slots over two busy cycles
    flush_valid = 1'b1; flush_tag = 4'd2;
    #1 chk("R8 ready low in flush cycle", int'(ren_ready), 0);
    tick();
    flush_valid = 1'b0;
    #1 chk("R7 busy", int'(rb_busy), 1);
    ren_valid = 1'b1; ren_alloc = 1'b0; retire_cnt = 2'd2;
    #1 chk("R8 ready low while busy", int'(ren_ready), 0);
    flush_valid = 1'b1; flush_tag = 4'd0;   // R10 must be ignored
    tick();
    flush_valid = 1'b0;
    #1 chk("R7 still busy", int'(rb_busy), 1);
    chk("R7 free after first step", int'(free_cnt), 4);
    tick();
    ren_valid = 1'b0; retire_cnt = 2'd0;
    #1 chk("R7 busy ends", int'(rb_busy), 0);
    chk("R7 free after walk", int'(free_cnt), 5);
    map_is("R7 restore log0", 0, 1);
    map_is("R7 restore log1", 1, 2);
    map_is("R10 log3 keeps slot0", 3, 9);
    map_is("R10 log5 keeps slot1", 5, 10);
    map_is("R8 no rename in walk log2", 2, 3);

    // R6 retire capped by held count, slots 0 and 1 return 4 and 6
    retire_cnt = 2'd3;
    tick();
    retire_cnt = 2'd0;
    #1 chk("R6 retire frees", int'(free_cnt), 7);
    rename(0, 1'b0, 0, 2);
    rename(0, 1'b1, 4, 3);
    chk("R3 free after alloc", int'(free_cnt), 6);
    retire_cnt = 2'd2;
    tick();
    retire_cnt = 2'd0;
    #1 chk("R6 zero old not freed", int'(free_cnt), 7);

    // R5 fill the log
    for (int i = 0; i < HD; i++) rename(7, 1'b0, 0, 4 + i);
    ren_alloc = 1'b0;
    #1 chk("R5 ready low when full", int'(ren_ready), 0);
    retire_cnt = 2'd3;
    tick();
    retire_cnt = 2'd0;
    #1 chk("R6 cap frees one", int'(free_cnt), 8);
    chk("R5 ready after retire", int'(ren_ready), 1);
    rename(6, 1'b0, 0, 12);
    rename(6, 1'b0, 0, 13);
    ren_alloc = 1'b0;
    #1 chk("R6 retire capped at STEPS", int'(ren_ready), 0);
    ren_alloc = 1'b1;
    #1 chk("R3 lowest free preg", int'(ren_new_preg), 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule